// File: doc/BRIEF.md
# Token-Stream Channel Arbiter

This block arbitrates a set of receive channels that many nodes may write but only one node reads. Each channel owns one circulating permission token. A free token moves from node to node around a ring of `N_NODES` nodes and takes one full round trip of `RTT` cycles. A node that wants a channel raises a request bit. The first requesting node the token reaches captures it, provided that node still has room under its hold limit. The node keeps the token for a whole packet of eight flits, then drops it with a done strobe, and the token moves on from the next node.

The right to send also depends on receiver buffer space. Each channel has two virtual channels, and each virtual channel has `BUF_DEPTH` buffer credits. A capture takes one credit and so occupies one receiver buffer. When the receiver frees a buffer, its credit first travels back toward the injection point, where no sender can take it. It then travels forward past the senders. Only after both phases can it be captured again.

Top module: `oca_token_arbiter`

## Requirements
- R1: After reset no grant is asserted, the token of channel c sits at node c, and every virtual channel holds `BUF_DEPTH` credits with no buffer occupied.
- R2: No two nodes ever hold the token of the same channel at once.
- R3: A free token at node p is captured at a clock edge when `req_i[p*N_NODES+c]` is high, node p holds fewer than `MAX_HOLD` tokens and channel c has a credit. `grant_o[p*N_NODES+c]` rises after that edge, and a capture never happens without the request.
- R4: A free token that is not captured moves to the next node (index modulo `N_NODES`) once every `RTT/N_NODES` cycles. With the default parameters it moves once per cycle, so after a reset release a request by node 3 for channel 0 is granted after the fourth edge.
- R5: A node never holds more than `MAX_HOLD` (2) tokens, even though it may request all channels at once. When several tokens could reach the same node at one edge, channels are served in ascending index until that node's limit is reached. A token held at the start of the edge still counts toward the limit at that edge, even if the node releases it there.
- R6: `done_i[n*N_NODES+c]` while node n holds channel c releases the token at that edge: the grant falls and the token restarts at node n+1. It cannot be recaptured at that same edge. A done strobe for a token that the node does not hold has no effect.
- R7: A capture uses virtual channel 0 if it has a credit, otherwise virtual channel 1. `grant_vc_o` shows the chosen virtual channel (0 or 1) while the grant is held. A channel with no credit on either virtual channel grants nothing, and its token keeps circulating.
- R8: `buf_free_i[c*2+v]` (legal only while that virtual channel has an occupied buffer) returns one credit. The credit spends `RTT/2` cycles on the backward path and `RTT/2` cycles on the forward path, so it is counted `RTT` edges after the free edge and can first be used one edge later.
- R9: For every virtual channel, free credits plus credits in return flight plus occupied buffers always equal `BUF_DEPTH`. After all buffers are freed and returned, exactly `2*BUF_DEPTH` packets can be sent on a channel before further frees are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_NODES*N_NODES | Token request; bit n*N_NODES+c is node n asking for channel c |
| done_i | input | N_NODES*N_NODES | Packet-done strobe; bit n*N_NODES+c releases node n's token of channel c |
| buf_free_i | input | N_NODES*2 | Receiver buffer freed; bit c*2+v is channel c, virtual channel v |
| grant_o | output | N_NODES*N_NODES | Bit n*N_NODES+c high while node n holds channel c's token |
| grant_vc_o | output | N_NODES*N_NODES | Virtual channel used by the held grant at the same bit |

## Verification
A token in the wrong place shows at the ports as a grant that comes earlier or later than the distance from the token to the requester predicts. With default parameters that error appears within one ring circuit of 8 cycles. A credit that leaks or is duplicated shows as one packet too many or too few on a channel before it stalls, or as a grant that appears before the return time of `RTT` plus one edge has passed. A broken hold limit or a broken tie order shows as a third grant on one node, or as the wrong pair of channels captured at the same edge.

// File: rtl/oca_pkg.sv
package oca_pkg;
  localparam int unsigned NUM_VC = 2;
  localparam int unsigned PKT_FLITS = 8;
endpackage

// File: rtl/oca_delay_line.sv
module oca_delay_line #(
  parameter int unsigned LEN = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           d_i,
  output logic [LEN-1:0] taps_o
);
  generate
    if (LEN == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) taps_o <= '0;
        else         taps_o <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) taps_o <= '0;
        else         taps_o <= {taps_o[LEN-2:0], d_i};
    end
  endgenerate
endmodule

// File: rtl/oca_vc_return.sv
module oca_vc_return #(
  parameter int unsigned BUF_DEPTH = 2,
  parameter int unsigned RTT       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic free_i,
  input  logic take_i,
  output logic avail_o
);
  localparam int unsigned HALF = RTT / 2;
  localparam int unsigned CW   = $clog2(BUF_DEPTH + 1);

  logic [HALF-1:0] back_taps, fwd_taps;
  logic [CW-1:0]   credit_q, occ_q;
  logic            arrive;

  // backward leg: senders cannot see the credit
  oca_delay_line #(.LEN(HALF)) u_back (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(free_i), .taps_o(back_taps)
  );
  // forward leg: credit passes the senders
  oca_delay_line #(.LEN(HALF)) u_fwd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(back_taps[HALF-1]), .taps_o(fwd_taps)
  );

  assign arrive  = fwd_taps[HALF-1];
  assign avail_o = (credit_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(BUF_DEPTH);
      occ_q    <= '0;
    end else begin
      credit_q <= credit_q + CW'(arrive) - CW'(take_i);
      occ_q    <= occ_q + CW'(take_i) - CW'(free_i);
    end
  end

  // R9
  conserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit_q) + int'(occ_q) + $countones(back_taps) + $countones(fwd_taps) == int'(BUF_DEPTH));
  // R7
  take_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> credit_q != '0);
  // R8
  free_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> occ_q != '0);
endmodule

// File: rtl/oca_chan_arb.sv
module oca_chan_arb #(
  parameter int unsigned N_NODES  = 8,
  parameter int unsigned MAX_HOLD = 2,
  parameter int unsigned STEP     = 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_NODES*N_NODES-1:0]          req_i,
  input  logic [N_NODES*N_NODES-1:0]          done_i,
  input  logic [N_NODES*oca_pkg::NUM_VC-1:0]  vc_avail_i,
  output logic [N_NODES*oca_pkg::NUM_VC-1:0]  vc_take_o,
  output logic [N_NODES*N_NODES-1:0]          grant_o,
  output logic [N_NODES*N_NODES-1:0]          grant_vc_o
);
  localparam int unsigned NV = oca_pkg::NUM_VC;
  localparam int unsigned IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam int unsigned CW = $clog2(N_NODES + 1);

  logic          held_q [N_NODES];
  logic          held_d [N_NODES];
  logic [IW-1:0] holder_q [N_NODES];
  logic [IW-1:0] holder_d [N_NODES];
  logic [IW-1:0] pos_q [N_NODES];
  logic [IW-1:0] pos_d [N_NODES];
  logic          vc_q [N_NODES];
  logic          vc_d [N_NODES];
  logic [CW-1:0] cnt [N_NODES];
  logic          tick;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(N_NODES - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    if (STEP <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int unsigned SW = $clog2(STEP);
      logic [SW-1:0] step_q;
      assign tick = (step_q == SW'(STEP - 1));
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   step_q <= '0;
        else if (tick) step_q <= '0;
        else           step_q <= step_q + 1'b1;
    end
  endgenerate

  always_comb begin
    for (int n = 0; n < N_NODES; n++) cnt[n] = '0;
    for (int c = 0; c < N_NODES; c++)
      if (held_q[c]) cnt[holder_q[c]] = cnt[holder_q[c]] + 1'b1;
    vc_take_o = '0;
    for (int c = 0; c < N_NODES; c++) begin
      held_d[c]   = held_q[c];
      holder_d[c] = holder_q[c];
      pos_d[c]    = pos_q[c];
      vc_d[c]     = vc_q[c];
      if (held_q[c]) begin
        if (done_i[int'(holder_q[c])*N_NODES + c]) begin
          held_d[c] = 1'b0;
          pos_d[c]  = nxt(holder_q[c]);
        end
      end else if (req_i[int'(pos_q[c])*N_NODES + c] &&
                   (cnt[pos_q[c]] < CW'(MAX_HOLD)) &&
                   (vc_avail_i[c*NV] || vc_avail_i[c*NV+1])) begin
        held_d[c]   = 1'b1;
        holder_d[c] = pos_q[c];
        cnt[pos_q[c]] = cnt[pos_q[c]] + 1'b1;
        if (vc_avail_i[c*NV]) begin
          vc_d[c] = 1'b0;
          vc_take_o[c*NV] = 1'b1;
        end else begin
          vc_d[c] = 1'b1;
          vc_take_o[c*NV+1] = 1'b1;
        end
      end else if (tick) begin
        pos_d[c] = nxt(pos_q[c]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_NODES; c++) begin
        held_q[c]   <= 1'b0;
        holder_q[c] <= '0;
        pos_q[c]    <= IW'(c);
        vc_q[c]     <= 1'b0;
      end
    end else begin
      for (int c = 0; c < N_NODES; c++) begin
        held_q[c]   <= held_d[c];
        holder_q[c] <= holder_d[c];
        pos_q[c]    <= pos_d[c];
        vc_q[c]     <= vc_d[c];
      end
    end
  end

  always_comb begin
    for (int n = 0; n < N_NODES; n++)
      for (int c = 0; c < N_NODES; c++) begin
        grant_o[n*N_NODES+c]    = held_q[c] && (holder_q[c] == IW'(n));
        grant_vc_o[n*N_NODES+c] = held_q[c] && (holder_q[c] == IW'(n)) && vc_q[c];
      end
  end

  for (genvar n = 0; n < N_NODES; n++) begin : g_node_chk
    // R5
    hold_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(grant_o[n*N_NODES +: N_NODES]) <= MAX_HOLD);
    for (genvar c = 0; c < N_NODES; c++) begin : g_ch_chk
      // R3
      grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_o[n*N_NODES+c]) |-> $past(req_i[n*N_NODES+c]));
      // R6
      release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o[n*N_NODES+c] && done_i[n*N_NODES+c] |=> !grant_o[n*N_NODES+c]);
    end
  end
endmodule

// File: rtl/oca_token_arbiter.sv
module oca_token_arbiter #(
  parameter int unsigned N_NODES   = 8,
  parameter int unsigned RTT       = 8,
  parameter int unsigned MAX_HOLD  = 2,
  parameter int unsigned BUF_DEPTH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_NODES*N_NODES-1:0]   req_i,
  input  logic [N_NODES*N_NODES-1:0]   done_i,
  input  logic [N_NODES*2-1:0]         buf_free_i,
  output logic [N_NODES*N_NODES-1:0]   grant_o,
  output logic [N_NODES*N_NODES-1:0]   grant_vc_o
);
  localparam int unsigned NV   = oca_pkg::NUM_VC;
  localparam int unsigned STEP = RTT / N_NODES;

  logic [N_NODES*NV-1:0] vc_avail, vc_take;

  oca_chan_arb #(
    .N_NODES(N_NODES), .MAX_HOLD(MAX_HOLD), .STEP(STEP)
  ) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .done_i(done_i),
    .vc_avail_i(vc_avail), .vc_take_o(vc_take),
    .grant_o(grant_o), .grant_vc_o(grant_vc_o)
  );

  for (genvar i = 0; i < N_NODES*NV; i++) begin : g_vc
    oca_vc_return #(.BUF_DEPTH(BUF_DEPTH), .RTT(RTT)) u_ret (
      .clk_i(clk_i), .rst_ni(rst_ni), .free_i(buf_free_i[i]),
      .take_i(vc_take[i]), .avail_o(vc_avail[i])
    );
  end
endmodule

// File: tb/oca_token_arbiter_tb.sv
module oca_token_arbiter_tb;
  localparam int N = 8;
  localparam int RTT = 8;
  localparam int MAXH = 2;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*N-1:0] req = '0, done = '0;
  logic [N*2-1:0] bfree = '0;
  logic [N*N-1:0] grant, grant_vc;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  oca_token_arbiter #(.N_NODES(N), .RTT(RTT), .MAX_HOLD(MAXH), .BUF_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done), .buf_free_i(bfree),
    .grant_o(grant), .grant_vc_o(grant_vc)
  );

  // reference state (token moves one node per cycle: RTT/N == 1)
  bit m_held [N];
  int m_holder [N], m_pos [N], m_vc [N];
  int m_cred [N][2], m_occ [N][2];
  bit m_pipe [N][2][RTT];

  always @(posedge clk or negedge rst_n) begin
    int cnt [N];
    bit arrive [N][2];
    bit take [N][2];
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        m_held[c] = 0; m_holder[c] = 0; m_pos[c] = c; m_vc[c] = 0;
        for (int v = 0; v < 2; v++) begin
          m_cred[c][v] = DEPTH; m_occ[c][v] = 0;
          for (int k = 0; k < RTT; k++) m_pipe[c][v][k] = 0;
        end
      end
    end else begin
      for (int n = 0; n < N; n++) cnt[n] = 0;
      for (int c = 0; c < N; c++) if (m_held[c]) cnt[m_holder[c]]++;
      for (int c = 0; c < N; c++) begin
        take[c][0] = 0; take[c][1] = 0;
        if (m_held[c]) begin
          if (done[m_holder[c]*N+c]) begin
            m_held[c] = 0; m_pos[c] = (m_holder[c] + 1) % N;
          end
        end else if (req[m_pos[c]*N+c] && cnt[m_pos[c]] < MAXH &&
                     (m_cred[c][0] > 0 || m_cred[c][1] > 0)) begin
          m_held[c] = 1; m_holder[c] = m_pos[c]; cnt[m_pos[c]]++;
          m_vc[c] = (m_cred[c][0] > 0) ? 0 : 1;
          take[c][m_vc[c]] = 1;
        end else begin
          m_pos[c] = (m_pos[c] + 1) % N;
        end
      end
      for (int c = 0; c < N; c++)
        for (int v = 0; v < 2; v++) begin
          arrive[c][v] = m_pipe[c][v][RTT-1];
          for (int k = RTT-1; k > 0; k--) m_pipe[c][v][k] = m_pipe[c][v][k-1];
          m_pipe[c][v][0] = bfree[c*2+v];
          m_cred[c][v] = m_cred[c][v] - int'(take[c][v]) + int'(arrive[c][v]);
          m_occ[c][v]  = m_occ[c][v] + int'(take[c][v]) - int'(bfree[c*2+v]);
        end
    end
  end

  function automatic logic [N*N-1:0] exp_grant();
    logic [N*N-1:0] g = '0;
    for (int c = 0; c < N; c++) if (m_held[c]) g[m_holder[c]*N+c] = 1'b1;
    return g;
  endfunction

  function automatic logic [N*N-1:0] exp_vc();
    logic [N*N-1:0] g = '0;
    for (int c = 0; c < N; c++) if (m_held[c] && m_vc[c] == 1) g[m_holder[c]*N+c] = 1'b1;
    return g;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // wait for negedge and compare against the reference and invariants
  task automatic step(input string tag);
    @(negedge clk);
    chk(grant == exp_grant(), {tag, " grant vs model (R3 R4 R6)"}, grant, exp_grant());
    chk(grant_vc == exp_vc(), {tag, " vc vs model (R7 R8 R9)"}, grant_vc, exp_vc());
    for (int c = 0; c < N; c++) begin
      int k = 0;
      for (int n = 0; n < N; n++) k += int'(grant[n*N+c]);
      chk(k <= 1, "R2 one holder per channel", 64'(k), 64'd1);
    end
    for (int n = 0; n < N; n++)
      chk($countones(grant[n*N +: N]) <= MAXH, "R5 hold limit",
          64'($countones(grant[n*N +: N])), 64'(MAXH));
  endtask

  task automatic do_reset(input logic [N*N-1:0] req_at_release);
    @(negedge clk);
    rst_n = 1'b0; done = '0; bfree = '0; req = '0;
    @(negedge clk);
    chk(grant == '0 && grant_vc == '0, "R1 reset grants low", grant, 64'd0);
    req = req_at_release;
    rst_n = 1'b1;
  endtask

  // node n keeps requesting channel c, releases each grant; counts grants
  task automatic serve(input int n, input int c, input int cycles, output int got, output int vcs [8]);
    got = 0;
    req[n*N+c] = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      step("serve");
      done = '0;
      if (grant[n*N+c]) begin
        if (got < 8) vcs[got] = int'(grant_vc[n*N+c]);
        got++;
        done[n*N+c] = 1'b1;
      end
    end
    step("serve");
    done = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int got;
    int vcs [8];
    void'($urandom(32'd20240611));

    // R1/R4/R3: node 3 asks for channel 0 from reset release
    do_reset(64'd1 << 24);
    for (int i = 1; i <= 3; i++) begin
      step("R4");
      chk(grant == '0, "R4 token not yet at node 3", grant, 64'd0);
    end
    step("R3");
    chk(grant == (64'd1 << 24), "R3 R4 grant after 4th edge", grant, 64'd1 << 24);

    // R6: release, token restarts at node 4
    req = (64'd1 << 32) | (64'd1 << 16);
    done = (64'd1 << 24) | (64'd1 << 17);
    step("R6");
    chk(grant == '0, "R6 grant falls after done", grant, 64'd0);
    done = '0;
    step("R6");
    chk(grant == (64'd1 << 32), "R6 next node captures", grant, 64'd1 << 32);
    req = '0;
    done = 64'd1 << 32;
    step("R6");
    done = '0;
    chk(grant == '0, "R6 release node 4", grant, 64'd0);

    // R5: node 0 asks for all channels
    do_reset(64'hFF);
    step("R5");
    chk(grant == 64'h01, "R5 first capture", grant, 64'h01);
    step("R5");
    chk(grant == 64'h81, "R5 second capture", grant, 64'h81);
    for (int i = 0; i < 20; i++) step("R5");
    chk(grant == 64'h81, "R5 limit holds", grant, 64'h81);
    req = '0;
    done = 64'h81;
    step("R5");
    done = '0;

    // R7: channel 5 by node 1 uses vc0 twice then vc1 twice, then starves
    do_reset('0);
    serve(1, 5, 60, got, vcs);
    chk(got == 4, "R7 four packets on fresh channel", 64'(got), 64'd4);
    chk(vcs[0] == 0 && vcs[1] == 0 && vcs[2] == 1 && vcs[3] == 1, "R7 vc order",
        64'(vcs[0]*1000 + vcs[1]*100 + vcs[2]*10 + vcs[3]), 64'd11);
    for (int i = 0; i < 24; i++) step("R7");
    chk(grant[13] == 1'b0, "R7 no credit no grant", 64'(grant[13]), 64'd0);

    // R8: free vc1 buffer; credit usable only after RTT+1 edges
    bfree[11] = 1'b1;
    step("R8");
    bfree = '0;
    for (int i = 1; i < RTT; i++) begin
      step("R8");
      chk(grant[13] == 1'b0, "R8 credit still in flight", 64'(grant[13]), 64'd0);
    end
    got = 0;
    for (int i = 0; i < 12 && got == 0; i++) begin
      step("R8");
      if (grant[13]) begin
        got = 1;
        chk(grant_vc[13] == 1'b1, "R8 returned credit on vc1", 64'(grant_vc[13]), 64'd1);
      end
    end
    chk(got == 1, "R8 returned credit granted", 64'(got), 64'd1);
    req = '0;
    done = grant;
    step("R8");
    done = '0;

    // random traffic checked against the reference every cycle
    for (int i = 0; i < 3000; i++) begin
      req = {$urandom, $urandom} & {$urandom, $urandom};
      done = grant & {$urandom, $urandom};
      for (int c = 0; c < N; c++)
        for (int v = 0; v < 2; v++)
          bfree[c*2+v] = (m_occ[c][v] > 0) && ($urandom_range(2) == 0);
      step("R2 R9 random");
    end

    // R9: drain, free all buffers, then exactly 4 packets per channel
    req = '0;
    bfree = '0;
    for (int i = 0; i < 10; i++) begin
      done = grant;
      step("R9 drain");
    end
    done = '0;
    for (int i = 0; i < 2*DEPTH + 2; i++) begin
      for (int c = 0; c < N; c++)
        for (int v = 0; v < 2; v++) bfree[c*2+v] = (m_occ[c][v] > 0);
      step("R9 free");
    end
    bfree = '0;
    for (int i = 0; i < RTT + 4; i++) step("R9 settle");
    serve(6, 0, 60, got, vcs);
    chk(got == 2*DEPTH, "R9 credits conserved after traffic", 64'(got), 64'(2*DEPTH));
    req = '0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule